// File: doc/BRIEF.md
# Pipelined Execute Stage with Branch Redirect

This block is the execute step of a small in-order integer pipeline. Decoded instruction packets arrive over a valid/ready ingress and are captured into a single pipeline slot. A combinational ALU works on the slot's operands. A branch unit decides conditional branches and jumps, and the result packet goes to the memory step over a valid/ready egress.

Later stages send a backward path into the block. It carries forwarded values from the memory and writeback steps and a flat copy of the register file. The block returns a stall flag and a redirect target to earlier stages. A source that is still being loaded by the memory step holds the slot until the value can be forwarded. A taken branch or jump raises the redirect in the cycle its packet leaves, and any packet offered on the ingress in that same cycle is dropped.

Top module: `exe_stage`

## Requirements
- R1: After synchronous reset, out_valid, stall and redirect_valid are 0 and in_ready is 1.
- R2: in_ready is 1 when the slot is empty or its packet is handed downstream in the same cycle. A packet accepted with in_valid and in_ready high appears on out_valid one clock later.
- R3: While out_ready is low, a packet that is held keeps out_valid high and all out_* fields unchanged.
- R4: ALU ops are encoded as ADD=0, SUB=1, AND=2, OR=3, XOR=4, SLL=5, SRL=6, SRA=7, SLT=8 and SLTU=9. Shifts use the low 5 bits of operand B. Operand A is the PC when in_op1_pc=1 and rs1 otherwise. Operand B is in_imm when in_op2_imm=1 and rs2 otherwise.
- R5: A source value comes from the memory-step bypass if its register matches, otherwise from the writeback bypass if that matches, otherwise from the register file. Register 0 always reads zero.
- R6: When the memory step holds a load (mem_fwd_load=1) whose destination matches a used nonzero source, stall is 1 and both out_valid and in_ready are 0 until the match goes away.
- R7: Branch kinds are encoded as none=0, EQ=1, NE=2, LT=3, GE=4, LTU=5, GEU=6, JAL=7 and JALR=8. EQ and NE test the SUB result for zero. LT and GE use bit 0 of the SLT result, and LTU and GEU use bit 0 of the SLTU result. A taken conditional branch redirects to pc+imm.
- R8: JAL redirects to pc+imm. JALR redirects to the ALU sum with bit 0 cleared. For both jumps, out_alu is pc+4.
- R9: redirect_valid is high only in the cycle the branch packet transfers downstream. A packet offered on the ingress in that cycle is discarded and never reaches the egress.
- R10: out_pc, out_inst, out_rd, out_wb_sel, out_mem_op, out_csr_op and out_illegal carry the captured fields unchanged. out_store_data is the forwarded rs2 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Ingress packet valid |
| in_ready | output | 1 | Slot is free next cycle |
| in_pc | input | 32 | Instruction address |
| in_inst | input | 32 | Raw instruction word |
| in_alu_op | input | 4 | ALU operation code |
| in_br_kind | input | 4 | Branch kind code |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| in_rd | input | 5 | Destination register |
| in_use_rs1 | input | 1 | rs1 is read |
| in_use_rs2 | input | 1 | rs2 is read |
| in_op1_pc | input | 1 | Operand A is the PC |
| in_op2_imm | input | 1 | Operand B is the immediate |
| in_imm | input | 32 | Immediate value |
| in_wb_sel | input | 2 | Writeback source selector |
| in_mem_op | input | 3 | Memory access code |
| in_csr_op | input | 2 | CSR operation code |
| in_illegal | input | 1 | Illegal instruction flag |
| mem_fwd_valid | input | 1 | Memory step has a destination |
| mem_fwd_rd | input | 5 | Memory step destination |
| mem_fwd_data | input | 32 | Memory step forwarded value |
| mem_fwd_load | input | 1 | Memory step instruction is a load |
| wb_fwd_valid | input | 1 | Writeback step has a destination |
| wb_fwd_rd | input | 5 | Writeback step destination |
| wb_fwd_data | input | 32 | Writeback step forwarded value |
| rf_flat | input | 1024 | Register file, entry i at bits i*32+31..i*32 |
| stall | output | 1 | Slot held on a load-use hazard |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Redirect target |
| out_valid | output | 1 | Egress packet valid |
| out_ready | input | 1 | Downstream accepts |
| out_pc | output | 32 | Packet PC |
| out_inst | output | 32 | Packet instruction word |
| out_alu | output | 32 | ALU result or link address |
| out_store_data | output | 32 | Forwarded rs2 value |
| out_rd | output | 5 | Destination register |
| out_wb_sel | output | 2 | Writeback selector |
| out_mem_op | output | 3 | Memory access code |
| out_csr_op | output | 2 | CSR operation code |
| out_illegal | output | 1 | Illegal instruction flag |

## Verification
The ALU is driven from a table of operand pairs. The table includes sign-bit operands, which tell SRA from SRL and SLT from SLTU, and a shift amount above 31, which shows that only the low five bits are used. Each conditional branch kind is tried on operand pairs that make it both taken and not taken, so the code-to-condition mapping is exercised in both directions. A held packet is checked three times while its bypass sources are switched off one at a time, which tells each forwarding priority level apart. A stream under random back-pressure tells correct ready timing from lost or duplicated packets, and a wrong-path packet offered right behind a taken branch tells squashing apart from plain flow.

// File: rtl/exe_pkg.sv
package exe_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int REGW = $clog2(NREG);
    localparam int SHW  = $clog2(XLEN);
    localparam int NSRC = 2;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
        ALU_XOR = 4'd4, ALU_SLL = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
        ALU_SLT = 4'd8, ALU_SLTU = 4'd9
    } alu_op_e;

    typedef enum logic [3:0] {
        BR_NONE = 4'd0, BR_EQ = 4'd1, BR_NE = 4'd2, BR_LT = 4'd3,
        BR_GE = 4'd4, BR_LTU = 4'd5, BR_GEU = 4'd6, BR_JAL = 4'd7,
        BR_JALR = 4'd8
    } br_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [31:0]     inst;
        alu_op_e         alu_op;
        br_kind_e        br;
        logic [REGW-1:0] rs1;
        logic [REGW-1:0] rs2;
        logic [REGW-1:0] rd;
        logic            use_rs1;
        logic            use_rs2;
        logic            op1_pc;
        logic            op2_imm;
        logic [XLEN-1:0] imm;
        logic [1:0]      wb_sel;
        logic [2:0]      mem_op;
        logic [1:0]      csr_op;
        logic            illegal;
    } dec_pkt_t;

    typedef struct packed {
        logic            valid;
        logic [REGW-1:0] rd;
        logic [XLEN-1:0] data;
    } fwd_t;

    function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                                 input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b);
        logic [SHW-1:0] sh;
        sh = b[SHW-1:0];
        case (op)
            ALU_SUB:  return a - b;
            ALU_AND:  return a & b;
            ALU_OR:   return a | b;
            ALU_XOR:  return a ^ b;
            ALU_SLL:  return a << sh;
            ALU_SRL:  return a >> sh;
            ALU_SRA:  return $unsigned($signed(a) >>> sh);
            ALU_SLT:  return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: return {{(XLEN-1){1'b0}}, (a < b)};
            default:  return a + b;
        endcase
    endfunction

    function automatic logic is_jump(input br_kind_e br);
        return (br == BR_JAL) || (br == BR_JALR);
    endfunction
endpackage

// File: rtl/exe_operand_sel.sv
module exe_operand_sel import exe_pkg::*; (
    input  logic [REGW-1:0]      idx,
    input  logic                 used,
    input  fwd_t                 mem_fwd,
    input  logic                 mem_is_load,
    input  fwd_t                 wb_fwd,
    input  logic [NREG*XLEN-1:0] rf_flat,
    output logic [XLEN-1:0]      value,
    output logic                 load_wait
);
    always_comb begin
        load_wait = 1'b0;
        if (idx == '0) begin
            value = '0;
        end else if (mem_fwd.valid && (mem_fwd.rd == idx)) begin
            value     = mem_fwd.data;
            load_wait = used && mem_is_load;
        end else if (wb_fwd.valid && (wb_fwd.rd == idx)) begin
            value = wb_fwd.data;
        end else begin
            value = rf_flat[int'(idx)*XLEN +: XLEN];
        end
    end
endmodule

// File: rtl/exe_alu.sv
module exe_alu import exe_pkg::*; (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb y = alu_eval(op, a, b);
endmodule

// File: rtl/exe_branch_unit.sv
module exe_branch_unit import exe_pkg::*; (
    input  br_kind_e        br,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] alu_y,
    output logic            taken,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] link
);
    localparam logic [XLEN-1:0] INST_BYTES = XLEN'(4);

    always_comb begin
        case (br)
            BR_EQ:           taken = (alu_y == '0);
            BR_NE:           taken = (alu_y != '0);
            BR_LT, BR_LTU:   taken = alu_y[0];
            BR_GE, BR_GEU:   taken = !alu_y[0];
            BR_JAL, BR_JALR: taken = 1'b1;
            default:         taken = 1'b0;
        endcase
        if (br == BR_JALR) target = {alu_y[XLEN-1:1], 1'b0};
        else               target = pc + imm;
        link = pc + INST_BYTES;
    end
endmodule

// File: rtl/exe_stage.sv
module exe_stage import exe_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [XLEN-1:0]      in_pc,
    input  logic [31:0]          in_inst,
    input  logic [3:0]           in_alu_op,
    input  logic [3:0]           in_br_kind,
    input  logic [REGW-1:0]      in_rs1,
    input  logic [REGW-1:0]      in_rs2,
    input  logic [REGW-1:0]      in_rd,
    input  logic                 in_use_rs1,
    input  logic                 in_use_rs2,
    input  logic                 in_op1_pc,
    input  logic                 in_op2_imm,
    input  logic [XLEN-1:0]      in_imm,
    input  logic [1:0]           in_wb_sel,
    input  logic [2:0]           in_mem_op,
    input  logic [1:0]           in_csr_op,
    input  logic                 in_illegal,
    input  logic                 mem_fwd_valid,
    input  logic [REGW-1:0]      mem_fwd_rd,
    input  logic [XLEN-1:0]      mem_fwd_data,
    input  logic                 mem_fwd_load,
    input  logic                 wb_fwd_valid,
    input  logic [REGW-1:0]      wb_fwd_rd,
    input  logic [XLEN-1:0]      wb_fwd_data,
    input  logic [NREG*XLEN-1:0] rf_flat,
    output logic                 stall,
    output logic                 redirect_valid,
    output logic [XLEN-1:0]      redirect_pc,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [XLEN-1:0]      out_pc,
    output logic [31:0]          out_inst,
    output logic [XLEN-1:0]      out_alu,
    output logic [XLEN-1:0]      out_store_data,
    output logic [REGW-1:0]      out_rd,
    output logic [1:0]           out_wb_sel,
    output logic [2:0]           out_mem_op,
    output logic [1:0]           out_csr_op,
    output logic                 out_illegal
);
    dec_pkt_t        in_pkt, slot_q;
    logic            slot_v_q;
    fwd_t            mem_fwd, wb_fwd;
    logic [XLEN-1:0] src_val  [NSRC];
    logic [NSRC-1:0] src_wait;
    logic [REGW-1:0] src_idx  [NSRC];
    logic [NSRC-1:0] src_used;
    logic [XLEN-1:0] opa, opb, alu_y, br_target, link_addr;
    logic            br_taken, hazard, leave, capture;

    always_comb begin
        in_pkt.pc      = in_pc;
        in_pkt.inst    = in_inst;
        in_pkt.alu_op  = alu_op_e'(in_alu_op);
        in_pkt.br      = br_kind_e'(in_br_kind);
        in_pkt.rs1     = in_rs1;
        in_pkt.rs2     = in_rs2;
        in_pkt.rd      = in_rd;
        in_pkt.use_rs1 = in_use_rs1;
        in_pkt.use_rs2 = in_use_rs2;
        in_pkt.op1_pc  = in_op1_pc;
        in_pkt.op2_imm = in_op2_imm;
        in_pkt.imm     = in_imm;
        in_pkt.wb_sel  = in_wb_sel;
        in_pkt.mem_op  = in_mem_op;
        in_pkt.csr_op  = in_csr_op;
        in_pkt.illegal = in_illegal;
        mem_fwd        = '{valid: mem_fwd_valid, rd: mem_fwd_rd, data: mem_fwd_data};
        wb_fwd         = '{valid: wb_fwd_valid, rd: wb_fwd_rd, data: wb_fwd_data};
        src_idx[0]     = slot_q.rs1;
        src_idx[1]     = slot_q.rs2;
        src_used[0]    = slot_q.use_rs1;
        src_used[1]    = slot_q.use_rs2;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        exe_operand_sel u_sel (
            .idx        (src_idx[s]),
            .used       (src_used[s]),
            .mem_fwd    (mem_fwd),
            .mem_is_load(mem_fwd_load),
            .wb_fwd     (wb_fwd),
            .rf_flat    (rf_flat),
            .value      (src_val[s]),
            .load_wait  (src_wait[s])
        );
    end

    assign opa = slot_q.op1_pc  ? slot_q.pc  : src_val[0];
    assign opb = slot_q.op2_imm ? slot_q.imm : src_val[1];

    exe_alu u_alu (
        .op(slot_q.alu_op),
        .a (opa),
        .b (opb),
        .y (alu_y)
    );

    exe_branch_unit u_br (
        .br    (slot_q.br),
        .pc    (slot_q.pc),
        .imm   (slot_q.imm),
        .alu_y (alu_y),
        .taken (br_taken),
        .target(br_target),
        .link  (link_addr)
    );

    assign hazard         = slot_v_q && (|src_wait);
    assign leave          = slot_v_q && !hazard && out_ready;
    assign in_ready       = !slot_v_q || leave;
    assign redirect_valid = leave && br_taken;
    assign redirect_pc    = br_target;
    assign capture        = in_valid && in_ready && !redirect_valid;
    assign stall          = hazard;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v_q <= 1'b0;
            slot_q   <= '0;
        end else if (capture) begin
            slot_v_q <= 1'b1;
            slot_q   <= in_pkt;
        end else if (leave) begin
            slot_v_q <= 1'b0;
        end
    end

    assign out_valid      = slot_v_q && !hazard;
    assign out_pc         = slot_q.pc;
    assign out_inst       = slot_q.inst;
    assign out_alu        = is_jump(slot_q.br) ? link_addr : alu_y;
    assign out_store_data = src_val[1];
    assign out_rd         = slot_q.rd;
    assign out_wb_sel     = slot_q.wb_sel;
    assign out_mem_op     = slot_q.mem_op;
    assign out_csr_op     = slot_q.csr_op;
    assign out_illegal    = slot_q.illegal;

    // Slot contents cannot move while downstream refuses them.
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        slot_v_q && !out_ready |=> slot_v_q && $stable(slot_q));

    // An accepted, non-squashed packet occupies the slot next cycle.
    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !redirect_valid |=> slot_v_q);

    // A load-use wait blocks both directions.
    assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        stall |-> !in_ready && !out_valid);

    // Redirect only accompanies an actual egress transfer.
    assert_redirect_xfer_R9: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> out_valid && out_ready);

    // Wrong-path ingress packet is not kept.
    assert_squash_R9: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !slot_v_q);

    // Indirect jump targets are halfword aligned.
    assert_jalr_align_R8: assert property (@(posedge clk) disable iff (rst)
        redirect_valid && (slot_q.br == BR_JALR) |-> redirect_pc[0] == 1'b0);
endmodule

// File: tb/exe_stage_test.sv
module exe_stage_test;
    import exe_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic in_valid = 1'b0, in_ready;
    logic [31:0] in_pc = '0, in_inst = '0, in_imm = '0;
    logic [3:0]  in_alu_op = '0, in_br_kind = '0;
    logic [4:0]  in_rs1 = '0, in_rs2 = '0, in_rd = '0;
    logic        in_use_rs1 = 1'b0, in_use_rs2 = 1'b0, in_op1_pc = 1'b0, in_op2_imm = 1'b0;
    logic [1:0]  in_wb_sel = '0, in_csr_op = '0;
    logic [2:0]  in_mem_op = '0;
    logic        in_illegal = 1'b0;
    logic        mem_fwd_valid = 1'b0, mem_fwd_load = 1'b0, wb_fwd_valid = 1'b0;
    logic [4:0]  mem_fwd_rd = '0, wb_fwd_rd = '0;
    logic [31:0] mem_fwd_data = '0, wb_fwd_data = '0;
    logic [31:0] rf [32];
    logic [1023:0] rf_flat;
    logic        stall, redirect_valid, out_valid, out_illegal;
    logic        out_ready = 1'b1;
    logic [31:0] redirect_pc, out_pc, out_inst, out_alu, out_store_data;
    logic [4:0]  out_rd;
    logic [1:0]  out_wb_sel, out_csr_op;
    logic [2:0]  out_mem_op;

    always_comb for (int i = 0; i < 32; i++) rf_flat[i*32 +: 32] = rf[i];

    exe_stage uut (.*);

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pkt(input logic [3:0] op, input logic [3:0] br, input logic [4:0] r1,
                       input logic [4:0] r2, input logic a_pc, input logic b_imm,
                       input logic [31:0] imm, input logic [31:0] pc);
        in_alu_op = op; in_br_kind = br; in_rs1 = r1; in_rs2 = r2;
        in_use_rs1 = 1'b1; in_use_rs2 = !b_imm; in_op1_pc = a_pc; in_op2_imm = b_imm;
        in_imm = imm; in_pc = pc; in_inst = pc ^ 32'h13; in_rd = 5'd7;
        in_wb_sel = 2'd1; in_mem_op = 3'd0; in_csr_op = 2'd0; in_illegal = 1'b0;
        in_valid = 1'b1;
    endtask

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  br;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] y;
        logic        taken;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 4'd0, 32'd5,        32'd7,        32'd12,       1'b0},
        '{4'd1, 4'd0, 32'd5,        32'd7,        32'hFFFFFFFE, 1'b0},
        '{4'd2, 4'd0, 32'hF0F0,     32'hFF00,     32'hF000,     1'b0},
        '{4'd3, 4'd0, 32'hF0F0,     32'h0F0F,     32'hFFFF,     1'b0},
        '{4'd4, 4'd0, 32'hFFFF,     32'h00FF,     32'hFF00,     1'b0},
        '{4'd5, 4'd0, 32'd1,        32'd31,       32'h80000000, 1'b0},
        '{4'd6, 4'd0, 32'h80000000, 32'd4,        32'h08000000, 1'b0},
        '{4'd7, 4'd0, 32'h80000000, 32'd4,        32'hF8000000, 1'b0},
        '{4'd8, 4'd0, 32'hFFFFFFFF, 32'd1,        32'd1,        1'b0},
        '{4'd9, 4'd0, 32'hFFFFFFFF, 32'd1,        32'd0,        1'b0},
        '{4'd5, 4'd0, 32'd1,        32'd33,       32'd2,        1'b0},
        '{4'd1, 4'd1, 32'd9,        32'd9,        32'd0,        1'b1},
        '{4'd1, 4'd2, 32'd9,        32'd9,        32'd0,        1'b0},
        '{4'd8, 4'd3, 32'hFFFFFFFF, 32'd1,        32'd1,        1'b1},
        '{4'd8, 4'd4, 32'hFFFFFFFF, 32'd1,        32'd1,        1'b0},
        '{4'd9, 4'd5, 32'hFFFFFFFF, 32'd1,        32'd0,        1'b0},
        '{4'd9, 4'd6, 32'hFFFFFFFF, 32'd1,        32'd0,        1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 32'(i) * 32'h11;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        chk("R1 stall", 32'(stall), 32'd0);
        chk("R1 redirect", 32'(redirect_valid), 32'd0);

        // ALU and conditional branch table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            rf[1] = VECS[v].a; rf[2] = VECS[v].b;
            pkt(VECS[v].op, VECS[v].br, 5'd1, 5'd2, 1'b0, 1'b0, 32'h40, 32'h1000);
            @(negedge clk);
            in_valid = 1'b0; #1;
            chk("R2 out_valid after one clock", 32'(out_valid), 32'd1);
            chk("R4 alu result", out_alu, VECS[v].y);
            chk("R7 branch decision", 32'(redirect_valid), 32'(VECS[v].taken));
            if (VECS[v].taken) chk("R7 branch target", redirect_pc, 32'h1040);
        end

        // Pass-through fields, operand A from PC
        @(negedge clk);
        rf[2] = 32'hCAFE0001;
        pkt(4'd0, 4'd0, 5'd1, 5'd2, 1'b1, 1'b1, 32'h10, 32'h4400);
        in_rd = 5'd19; in_wb_sel = 2'd2; in_mem_op = 3'd5; in_csr_op = 2'd3; in_illegal = 1'b1;
        in_use_rs2 = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; #1;
        chk("R4 pc+imm operands", out_alu, 32'h4410);
        chk("R10 pc", out_pc, 32'h4400);
        chk("R10 inst", out_inst, 32'h4400 ^ 32'h13);
        chk("R10 rd", 32'(out_rd), 32'd19);
        chk("R10 wb_sel", 32'(out_wb_sel), 32'd2);
        chk("R10 mem_op", 32'(out_mem_op), 32'd5);
        chk("R10 csr_op", 32'(out_csr_op), 32'd3);
        chk("R10 illegal", 32'(out_illegal), 32'd1);
        chk("R10 store data", out_store_data, 32'hCAFE0001);

        // Jumps
        @(negedge clk);
        pkt(4'd0, 4'd7, 5'd0, 5'd0, 1'b1, 1'b1, 32'h100, 32'h2000);
        @(negedge clk);
        in_valid = 1'b0; #1;
        chk("R8 JAL redirect", 32'(redirect_valid), 32'd1);
        chk("R8 JAL target", redirect_pc, 32'h2100);
        chk("R8 JAL link", out_alu, 32'h2004);
        @(negedge clk);
        rf[1] = 32'h3001;
        pkt(4'd0, 4'd8, 5'd1, 5'd0, 1'b0, 1'b1, 32'h4, 32'h2200);
        @(negedge clk);
        in_valid = 1'b0; #1;
        chk("R8 JALR target", redirect_pc, 32'h3004);
        chk("R8 JALR link", out_alu, 32'h2204);

        // Redirect squash and not-taken flow
        @(negedge clk);
        rf[1] = 32'd9; rf[2] = 32'd9;
        pkt(4'd1, 4'd1, 5'd1, 5'd2, 1'b0, 1'b0, 32'h40, 32'h1000);
        @(negedge clk);
        pkt(4'd0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b1, 32'h1, 32'h1004); #1;
        chk("R9 redirect on transfer", 32'(redirect_valid), 32'd1);
        chk("R2 ready while leaving", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0; #1;
        chk("R9 wrong-path dropped", 32'(out_valid), 32'd0);
        @(negedge clk);
        pkt(4'd1, 4'd2, 5'd1, 5'd2, 1'b0, 1'b0, 32'h40, 32'h1100);
        @(negedge clk);
        pkt(4'd0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b1, 32'h1, 32'h1104); #1;
        chk("R9 no redirect not taken", 32'(redirect_valid), 32'd0);
        @(negedge clk);
        in_valid = 1'b0; #1;
        chk("R9 follower kept", out_pc, 32'h1104);
        chk("R9 follower valid", 32'(out_valid), 32'd1);

        // Forwarding priority under a held slot
        @(negedge clk);
        out_ready = 1'b0; rf[3] = 32'd1;
        wb_fwd_valid = 1'b1; wb_fwd_rd = 5'd3; wb_fwd_data = 32'd2;
        mem_fwd_valid = 1'b1; mem_fwd_rd = 5'd3; mem_fwd_data = 32'd3; mem_fwd_load = 1'b0;
        pkt(4'd0, 4'd0, 5'd3, 5'd0, 1'b0, 1'b1, 32'h0, 32'h6000);
        @(negedge clk);
        in_valid = 1'b0; #1;
        chk("R5 memory bypass first", out_alu, 32'd3);
        mem_fwd_valid = 1'b0; #1;
        chk("R5 writeback bypass second", out_alu, 32'd2);
        wb_fwd_valid = 1'b0; #1;
        chk("R5 register file last", out_alu, 32'd1);
        @(negedge clk); #1;
        chk("R3 held valid", 32'(out_valid), 32'd1);
        chk("R3 held pc", out_pc, 32'h6000);
        out_ready = 1'b1;
        @(negedge clk);
        mem_fwd_valid = 1'b1; mem_fwd_rd = 5'd0; mem_fwd_data = 32'd9;
        pkt(4'd0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b1, 32'h0, 32'h6100);
        @(negedge clk);
        in_valid = 1'b0; #1;
        chk("R5 x0 reads zero", out_alu, 32'd0);
        mem_fwd_valid = 1'b0;

        // Load-use stall
        @(negedge clk);
        pkt(4'd0, 4'd0, 5'd5, 5'd0, 1'b0, 1'b1, 32'h1, 32'h5000);
        @(negedge clk);
        mem_fwd_valid = 1'b1; mem_fwd_rd = 5'd5; mem_fwd_load = 1'b1; mem_fwd_data = 32'hDEAD;
        pkt(4'd0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b1, 32'h2, 32'h5004); #1;
        chk("R6 stall raised", 32'(stall), 32'd1);
        chk("R6 out_valid low", 32'(out_valid), 32'd0);
        chk("R6 in_ready low", 32'(in_ready), 32'd0);
        @(negedge clk);
        mem_fwd_valid = 1'b0; mem_fwd_load = 1'b0;
        wb_fwd_valid = 1'b1; wb_fwd_rd = 5'd5; wb_fwd_data = 32'h77; #1;
        chk("R6 stall released", 32'(stall), 32'd0);
        chk("R6 forwarded load value", out_alu, 32'h78);
        chk("R6 held pc", out_pc, 32'h5000);
        @(negedge clk);
        in_valid = 1'b0; wb_fwd_valid = 1'b0; #1;
        chk("R6 next packet after stall", out_pc, 32'h5004);

        // Stream under random back-pressure
        begin
            int sent = 0, recv = 0, cyc = 0;
            @(negedge clk);
            while (recv < 24 && cyc < 2000) begin
                out_ready = ($urandom % 3) != 0;
                if (sent < 24) pkt(4'd0, 4'd0, 5'd0, 5'd0, 1'b0, 1'b1, 32'(sent + 100), 32'(sent * 4));
                else in_valid = 1'b0;
                #1;
                if (out_valid && out_ready) begin
                    chk("R2 stream order", out_alu, 32'(recv + 100));
                    recv++;
                end
                if (in_valid && in_ready) sent++;
                @(negedge clk);
                cyc++;
            end
            in_valid = 1'b0;
            chk("R3 stream count", 32'(recv), 32'd24);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule